// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block decides, row by row, whether a DRAM row needs a refresh in the current 64 ms window. It does not refresh every row at one fixed interval. Rows found to be weak during profiling are loaded into one of two Bloom filters. The short-retention filter holds 2048 bits and is probed by 10 hashes. The medium-retention filter holds 8192 bits and is probed by 6 hashes. Each hash is a fixed XOR-parity matrix applied to the row address.

Each pulse on the time-base tick opens a new 64 ms window. In that window a row counter walks every row from 0 to the last. For each row the scheduler probes both filters, picks the row's period, and raises a per-row refresh request toward the command issuer. It raises the request only when the row is due in that window.

A row can hit a filter falsely, which only adds refreshes. A row that was inserted can never miss, because no bit is ever cleared on its own. The filters are emptied only as a whole.

Top module: `retention_refresh_sched`

## Requirements
- R1: After reset `req_valid_o` is low and stays low until the first tick is accepted.
- R2: A row inserted with `ins_bin_i`=0 (short bin) is requested in every window.
- R3: A row inserted with `ins_bin_i`=1 (medium bin) is requested in every window whose index is even.
- R4: In every window whose index modulo 4 is 0, every row is requested exactly once. The first tick accepted after reset opens window 0, and each later accepted tick adds 1 to the index.
- R5: A row present in both filters follows the short period, so it is requested in odd windows too.
- R6: `clear_i` empties both filters. An insert presented in the same cycle as the clear is discarded, so an odd window that follows issues no request.
- R7: Requests use a valid/ready handshake. While `req_ready_i` is low, `req_valid_o` and `req_row_o` hold. Within a window the rows are requested in strictly ascending order, and no row is requested twice.
- R8: An insert stalls the row walk for the cycle in which it writes. A row inserted in the middle of a walk is still requested in later windows. Later inserts never remove an earlier row's membership.
- R9: With both filters empty, windows with index 1, 2 or 3 issue no request.
- R10: A tick that arrives while a walk or a request is in progress is ignored and does not advance the window index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Window tick (one pulse per 64 ms) |
| clear_i | input | 1 | Clears both filters |
| ins_valid_i | input | 1 | Insert strobe for a profiled weak row |
| ins_row_i | input | ROW_W | Row address to insert |
| ins_bin_i | input | 1 | Bin select: 0 = short (64 ms), 1 = medium (128 ms) |
| req_valid_o | output | 1 | Refresh request valid |
| req_ready_i | input | 1 | Command issuer accepts the request |
| req_row_o | output | ROW_W | Row to refresh |

## Verification
The bench goes after several failure modes, each with a visible symptom:
- Window numbering. A scheduler that let a tick during a busy walk advance the index would make the full-refresh window arrive one tick early.
- Bin priority. A scheduler that gave the medium period priority for a row in both bins would skip that row in odd windows.
- Inserts during a walk. An insert that lost the stall race would either drop the row, so it would be missing from later windows, or corrupt the walk order.
- Clear against insert. A clear that lost to a simultaneous insert would leave a row that is requested in the next odd window.
- Handshake. A request that changed while ready was low would show up as a row mismatch or a duplicate.

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched #(
  parameter int ROW_W     = 10,
  parameter int BIN1_BITS = 2048,
  parameter int BIN1_HASH = 10,
  parameter int BIN2_BITS = 8192,
  parameter int BIN2_HASH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic             ins_valid_i,
  input  logic [ROW_W-1:0] ins_row_i,
  input  logic             ins_bin_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [ROW_W-1:0] req_row_o
);
  localparam int B1_IW = $clog2(BIN1_BITS);
  localparam int B2_IW = $clog2(BIN2_BITS);
  localparam logic [ROW_W-1:0] LAST_ROW = '1;

  logic [BIN1_BITS-1:0] filt1;
  logic [BIN2_BITS-1:0] filt2;
  logic [ROW_W-1:0] row;
  logic [1:0] cur_win, next_win;
  logic walking, hit1, hit2, due;

  function automatic logic [ROW_W-1:0] hmask(input int unsigned salt);
    logic [31:0] x;
    x = salt * 32'h9E3779B1 + 32'h7F4A7C15;
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 13);
    x = x * 32'h297A2D39;
    x = x ^ (x >> 16);
    if (x[ROW_W-1:0] == '0) x[0] = 1'b1;
    return x[ROW_W-1:0];
  endfunction

  function automatic logic [B1_IW-1:0] idx1(input logic [ROW_W-1:0] r, input int k);
    logic [B1_IW-1:0] v;
    for (int j = 0; j < B1_IW; j++) v[j] = ^(r & hmask(1024 + k * 32 + j));
    return v;
  endfunction

  function automatic logic [B2_IW-1:0] idx2(input logic [ROW_W-1:0] r, input int k);
    logic [B2_IW-1:0] v;
    for (int j = 0; j < B2_IW; j++) v[j] = ^(r & hmask(2048 + k * 32 + j));
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      filt1 <= '0;
      filt2 <= '0;
    end else if (ins_valid_i) begin
      if (!ins_bin_i) for (int k = 0; k < BIN1_HASH; k++) filt1[idx1(ins_row_i, k)] <= 1'b1;
      else            for (int k = 0; k < BIN2_HASH; k++) filt2[idx2(ins_row_i, k)] <= 1'b1;
    end
  end

  always_comb begin
    hit1 = 1'b1;
    hit2 = 1'b1;
    for (int k = 0; k < BIN1_HASH; k++) hit1 = hit1 & filt1[idx1(row, k)];
    for (int k = 0; k < BIN2_HASH; k++) hit2 = hit2 & filt2[idx2(row, k)];
  end

  assign due       = hit1 | (hit2 & ~cur_win[0]) | (cur_win == 2'd0);
  assign req_row_o = row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walking     <= 1'b0;
      req_valid_o <= 1'b0;
      row         <= '0;
      cur_win     <= 2'd0;
      next_win    <= 2'd0;
    end else if (req_valid_o) begin
      if (req_ready_i) begin
        req_valid_o <= 1'b0;
        if (row == LAST_ROW) walking <= 1'b0;
        else row <= row + 1'b1;
      end
    end else if (walking) begin
      if (!ins_valid_i) begin
        if (due) req_valid_o <= 1'b1;
        else if (row == LAST_ROW) walking <= 1'b0;
        else row <= row + 1'b1;
      end
    end else if (tick_i) begin
      walking  <= 1'b1;
      row      <= '0;
      cur_win  <= next_win;
      next_win <= next_win + 2'd1;
    end
  end

  // R7
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_row_o));

  // R7
  req_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> walking);

  // R8
  stall_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walking && !req_valid_o && ins_valid_i |=> !req_valid_o && $stable(req_row_o));

  // R4
  win0_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walking && !req_valid_o && !ins_valid_i && cur_win == 2'd0 |=> req_valid_o);

  // R6
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !hit1 && !hit2);
endmodule

// File: tb/sim_retention_refresh_sched.sv
`timescale 1ns/1ps
module sim_retention_refresh_sched;
  localparam int ROW_W = 8;
  localparam int ROWS  = 1 << ROW_W;
  localparam int NWEAK = 8;
  // {bin, row}: bin 0 = short, 1 = medium; row 77 sits in both
  localparam logic [8:0] WEAK [NWEAK] = '{
    {1'b0, 8'd3}, {1'b0, 8'd77}, {1'b0, 8'd200}, {1'b1, 8'd12},
    {1'b1, 8'd77}, {1'b1, 8'd150}, {1'b1, 8'd255}, {1'b1, 8'd0}};

  logic clk = 0, rst_n = 0, tick = 0, clr = 0, ins_v = 0, ins_bin = 0, rdy = 0;
  logic [ROW_W-1:0] ins_row = '0;
  logic req_v;
  logic [ROW_W-1:0] req_row;

  int tests = 0, fails = 0, cnt = 0, last = 0, order_err = 0;
  logic [ROWS-1:0] seen = '0;
  logic prev_v = 0, prev_r = 0;
  logic [ROW_W-1:0] prev_row = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #2 clk = ~clk;

  retention_refresh_sched #(.ROW_W(ROW_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .clear_i(clr),
    .ins_valid_i(ins_v), .ins_row_i(ins_row), .ins_bin_i(ins_bin),
    .req_valid_o(req_v), .req_ready_i(rdy), .req_row_o(req_row));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rdy  = lfsr[0] | lfsr[5];
    if (rst_n) begin
      if (prev_v && !prev_r && (!req_v || req_row != prev_row)) order_err++;
      if (req_v && rdy) begin
        if (seen[req_row] || (cnt > 0 && int'(req_row) <= last)) order_err++;
        seen[req_row] = 1'b1;
        cnt++;
        last = int'(req_row);
      end
    end
    prev_v = req_v; prev_r = rdy; prev_row = req_row;
  end

  task automatic run_window(input bit extra_tick, input bit mid_insert);
    seen = '0; cnt = 0; order_err = 0;
    for (int c = 0; c < ROWS * 8; c++) begin
      @(negedge clk);
      tick  = (c == 0) || (extra_tick && c == 20);
      ins_v = mid_insert && (c == 30 || c == 31);
      ins_row = (c == 30) ? 8'd40 : 8'd41;
      ins_bin = 1'b0;
    end
    @(negedge clk);
    tick = 0; ins_v = 0;
  endtask

  task automatic insert(input logic [ROW_W-1:0] r, input logic b);
    @(negedge clk);
    ins_v = 1; ins_row = r; ins_bin = b;
    @(negedge clk);
    ins_v = 0;
  endtask

  task automatic check_table(input int idx, input string tag);
    for (int e = 0; e < NWEAK; e++) begin
      if (!WEAK[e][8]) chk(seen[WEAK[e][7:0]] == 1'b1, "R2 short-bin row due", int'(seen[WEAK[e][7:0]]), 1);
      else if (idx % 2 == 0) chk(seen[WEAK[e][7:0]] == 1'b1, "R3 medium-bin row due in even window", int'(seen[WEAK[e][7:0]]), 1);
    end
    chk(seen[77] == 1'b1, {"R5 both-bin row uses short period ", tag}, int'(seen[77]), 1);
    chk(order_err == 0, "R7 ascending, no duplicate, held request", order_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_v == 1'b0, "R1 idle after reset", int'(req_v), 0);
    repeat (10) @(negedge clk);
    chk(req_v == 1'b0, "R1 no request without tick", int'(req_v), 0);

    run_window(1'b1, 1'b0);                 // window 0, stray tick mid-walk
    chk(cnt == ROWS, "R4 all rows in window 0", cnt, ROWS);
    chk(order_err == 0, "R7 order in full window", order_err, 0);
    for (int w = 1; w < 4; w++) begin
      run_window(1'b0, 1'b0);
      chk(cnt == 0, "R9 empty filters idle window", cnt, 0);
    end
    run_window(1'b0, 1'b0);                 // window 4 -> index 0
    chk(cnt == ROWS, "R10 stray tick did not advance index", cnt, ROWS);

    for (int e = 0; e < NWEAK; e++) insert(WEAK[e][7:0], WEAK[e][8]);
    run_window(1'b0, 1'b1);                 // index 1, inserts mid-walk
    check_table(1, "odd");
    chk(cnt >= 3, "R8 walk completes around inserts", cnt, 3);
    run_window(1'b0, 1'b0);                 // index 2
    check_table(2, "even");
    run_window(1'b0, 1'b0);                 // index 3
    check_table(3, "odd");
    chk(seen[40] && seen[41], "R8 mid-walk inserts remain members", int'(seen[40]) + int'(seen[41]), 2);
    run_window(1'b0, 1'b0);                 // index 0
    chk(cnt == ROWS, "R4 all rows in later window 0", cnt, ROWS);

    @(negedge clk);
    clr = 1; ins_v = 1; ins_row = 8'd99; ins_bin = 1'b0;
    @(negedge clk);
    clr = 0; ins_v = 0;
    run_window(1'b0, 1'b0);                 // index 1
    chk(cnt == 0, "R6 clear empties filters and drops insert", cnt, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule